// File: doc/BRIEF.md
# I2C Target Register Interface

This block lets an external I2C controller read and write a small bank of 8-bit registers. The serial clock and data lines are first synchronised to the system clock. Each line then passes through a hold-time filter, so that a bus pulse shorter than a set number of system clocks never reaches the protocol logic. The filtered lines feed a START/STOP and clock-edge detector and a byte engine. The engine frames bits into bytes, matches the fixed 7-bit target address 0x59 and answers each byte with an acknowledge.

In a write, the first data byte after the address sets a register pointer. Each byte after that is stored at the pointer, and the pointer then advances. A read returns the register at the pointer and advances after every byte the controller acknowledges. A controller NACK ends the read and sends the engine back to idle. A repeated START keeps the pointer, so a write that only sets the pointer can be followed by a read. The block drives SDA only as an open-drain pull-down enable. The whole register bank is visible at all times on a flat parallel output for the rest of the chip.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset every register reads 0 on `regs_o` and `sda_oe` is 0, so the bus is released.
- R2: A pulse on `scl_i` or `sda_i` that lasts fewer than FILT_CYCLES system clocks has no effect on the protocol. With the default of 10, a 5-clock pulse is ignored on either line.
- R3: When the first byte after START carries any address other than 7'h59, the block never asserts `sda_oe` before the next START and leaves every register unchanged.
- R4: The first byte after START is the address in bits 7..1, MSB first, and the direction in bit 0 (1 = read, 0 = write). For address 7'h59 the block holds `sda_oe` at 1 during the high phase of the 9th clock, which is an ACK.
- R5: In a write, the low log2(NUM_REGS) bits of the first data byte load the pointer. Each later byte is ACKed, stored at the pointer, and the pointer then advances by one. Register i appears on `regs_o[8*i+7:8*i]`.
- R6: The pointer wraps from NUM_REGS-1 to 0, in writes and in reads.
- R7: In a read, each byte sent is the register at the pointer, MSB first. `sda_oe` = 1 drives a 0 bit. The pointer advances after each byte the controller ACKs and stays put after a NACKed byte.
- R8: After a controller NACK the block goes idle and releases SDA. Further clocks without a START get no response.
- R9: A repeated START keeps the pointer value.
- R10: A STOP at any point returns the block to idle, and a partly received byte is not written.
- R11: `sda_oe` changes only while the filtered SCL is low.
- R12: The block works at both a 1 MHz and a 100 kHz bit rate with the default filter setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 8*NUM_REGS | All registers, register i at bits 8*i+7 : 8*i |

## Verification
The assertions assume a well-behaved controller. After filtering, SDA moves only while SCL is low, except when the controller makes a START or STOP. No STOP is attempted while the block holds SDA low, and each held level lasts well beyond the filter window. The stimulus keeps to this. The bench controller sets data a quarter bit after SCL falls and holds each phase for 50 or 500 system clocks. It injects glitches only as 5-clock pulses, which the filter must remove.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } tgt_state_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
   parameter int unsigned HOLD_CYCLES = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RESET_LEVEL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   if (HOLD_CYCLES == 0) begin : g_bypass
      assign filt_o = sync_out;
   end else begin : g_hold
      logic [CNT_W-1:0] cnt;
      logic             level;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= '0;
            level <= RESET_LEVEL;
         end else if (sync_out == level) begin
            cnt <= '0;
         end else if (cnt == CNT_W'(HOLD_CYCLES - 1)) begin
            cnt   <= '0;
            level <= sync_out;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
      assign filt_o = level;

      // R2: the filtered level only moves to a value the synchroniser has been showing
      p_follows_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (level != $past(level)) |-> ($past(sync_out) == level));
      // R2: the hold counter never runs past its window
      p_cnt_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
         cnt < CNT_W'(HOLD_CYCLES));
   end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_f;
         sda_prev <= sda_f;
      end
   end

   assign start_o = scl_f & scl_prev & sda_prev & ~sda_f;
   assign stop_o  = scl_f & scl_prev & ~sda_prev & sda_f;
   assign rise_o  = scl_f & ~scl_prev;
   assign fall_o  = ~scl_f & scl_prev;

   // R4: a bus condition and a clock edge never coincide
   p_events_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0]  TGT_ADDR = 7'h59,
   parameter int unsigned IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              fall_i,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [BYTE_W-1:0] rd_data
);
   if (IDX_W < 1 || IDX_W > BYTE_W) begin : g_bad_idx
      $error("IDX_W must lie between 1 and the byte width");
   end

   tgt_state_e        state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [IDX_W-1:0]  ptr;
   logic              ptr_pending;
   logic              rw;
   logic              acked;

   assign rd_idx = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bitcnt      <= '0;
         shreg       <= '0;
         ptr         <= '0;
         ptr_pending <= 1'b0;
         rw          <= 1'b0;
         acked       <= 1'b0;
         sda_oe      <= 1'b0;
         wr_en       <= 1'b0;
         wr_idx      <= '0;
         wr_data     <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_i) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_i) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (rise_i) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_f};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (fall_i && bitcnt == 4'd8) begin
                     if (shreg[7:1] == TGT_ADDR) begin
                        state  <= ST_ADDR_ACK;
                        sda_oe <= 1'b1;
                        rw     <= shreg[0];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (fall_i) begin
                     bitcnt <= '0;
                     if (rw) begin
                        state  <= ST_RD;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        state       <= ST_WR;
                        sda_oe      <= 1'b0;
                        ptr_pending <= 1'b1;
                     end
                  end
               end
               ST_WR: begin
                  if (rise_i) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_f};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (fall_i && bitcnt == 4'd8) begin
                     state  <= ST_WR_ACK;
                     sda_oe <= 1'b1;
                     if (ptr_pending) begin
                        ptr         <= shreg[IDX_W-1:0];
                        ptr_pending <= 1'b0;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (fall_i) begin
                     state  <= ST_WR;
                     bitcnt <= '0;
                     sda_oe <= 1'b0;
                  end
               end
               ST_RD: begin
                  if (fall_i) begin
                     if (bitcnt == 4'd7) begin
                        state  <= ST_RD_ACK;
                        sda_oe <= 1'b0;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (rise_i) begin
                     acked <= ~sda_f;
                     if (!sda_f) ptr <= ptr + 1'b1;
                  end else if (fall_i) begin
                     if (acked) begin
                        state  <= ST_RD;
                        bitcnt <= '0;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R11: while the filtered clock stays high the data drive does not move
   p_oe_steady_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f) && !start_i && !stop_i) |-> $stable(sda_oe));
   // R3: the address acknowledge phase is only reached with a matching address
   p_ack_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> (shreg[7:1] == TGT_ADDR));
   // R8: an idle target never holds the bus
   p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);
   // R6: every stored byte moves the pointer one step, wrapping at the top
   p_ptr_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == IDX_W'(wr_idx + 1'b1)));
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [BYTE_W-1:0]          rd_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
   logic [BYTE_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_REGS; i++)
            if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[g*BYTE_W +: BYTE_W] = mem[g];
   end

   // R5: a write strobe lands its byte in the selected register
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 16,
   parameter logic [6:0]  TGT_ADDR    = 7'h59,
   parameter int unsigned FILT_CYCLES = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (NUM_REGS > 256) begin : g_bad_depth
      $error("NUM_REGS must be addressable by one data byte");
   end

   logic [1:0] raw_lines, filt_lines;
   assign raw_lines = {sda_i, scl_i};

   for (genvar l = 0; l < 2; l++) begin : g_line
      i2c_glitch_filter #(
         .HOLD_CYCLES (FILT_CYCLES),
         .SYNC_STAGES (SYNC_STAGES),
         .RESET_LEVEL (1'b1)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_lines[l]),
         .filt_o (filt_lines[l])
      );
   end

   logic start_ev, stop_ev, rise_ev, fall_ev;

   i2c_bus_events u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_lines[0]),
      .sda_f   (filt_lines[1]),
      .start_o (start_ev),
      .stop_o  (stop_ev),
      .rise_o  (rise_ev),
      .fall_o  (fall_ev)
   );

   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [BYTE_W-1:0] wr_data, rd_data;

   i2c_tgt_engine #(
      .TGT_ADDR (TGT_ADDR),
      .IDX_W    (IDX_W)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_lines[0]),
      .sda_f   (filt_lines[1]),
      .start_i (start_ev),
      .stop_i  (stop_ev),
      .rise_i  (rise_ev),
      .fall_i  (fall_ev),
      .sda_oe  (sda_oe),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   i2c_regbank #(
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .regs_flat (regs_o)
   );
endmodule

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;
   localparam int NREG = 16;
   localparam logic [6:0] ADDR = 7'h59;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
   logic sda_oe;
   logic [NREG*8-1:0] regs_o;
   logic sda_line, scl_i, sda_i;

   assign sda_line = sda_drv & ~sda_oe;
   assign scl_i    = scl_drv ^ scl_gl;
   assign sda_i    = sda_line ^ sda_gl;

   always #2.5 clk = ~clk;

   i2c_reg_target uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_oe(sda_oe), .regs_o(regs_o)
   );

   int checks = 0, errors = 0, q = 50, oe_moves = 0, m_ptr = 0;
   logic oe_seen = 1'b0;
   logic [7:0] m_regs [NREG];

   always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   // gm: 0 none, 1 short SDA pulse in the high phase, 2 short SCL pulse in the low phase
   task automatic bit_io(input logic b, input int gm, output logic seen);
      logic oe_a;
      wq(q); sda_drv = b;
      if (gm == 2) begin wq(q/2); scl_gl = 1'b1; wq(5); scl_gl = 1'b0; wq(q - q/2 - 5); end
      else wq(q);
      scl_drv = 1'b1;
      wq(20); oe_a = sda_oe;
      if (gm == 1) begin wq(q/2 - 20); sda_gl = 1'b1; wq(5); sda_gl = 1'b0; wq(q - q/2 - 5); end
      else wq(q - 20);
      seen = sda_line;
      wq(q - 1);
      if (sda_oe != oe_a) oe_moves++;
      wq(1); scl_drv = 1'b0;
   endtask

   task automatic bus_start();
      wq(q); sda_drv = 1'b0; wq(q); scl_drv = 1'b0;
   endtask
   task automatic bus_rstart();
      wq(q); sda_drv = 1'b1; wq(q); scl_drv = 1'b1; wq(q); sda_drv = 1'b0; wq(q); scl_drv = 1'b0;
   endtask
   task automatic bus_stop();
      wq(q); sda_drv = 1'b0; wq(q); scl_drv = 1'b1; wq(q); sda_drv = 1'b1; wq(q);
   endtask

   task automatic send_byte(input logic [7:0] b, input int gm, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_io(b[i], gm, s);
      bit_io(1'b1, 0, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin bit_io(1'b1, 0, s); b[i] = s; end
      bit_io(nack, 0, s);
   endtask

   task automatic check_regs(input string tag);
      int bad = 0, fa = 0, fe = 0;
      for (int i = 0; i < NREG; i++)
         if (regs_o[8*i +: 8] != m_regs[i]) begin
            if (bad == 0) begin fa = int'(regs_o[8*i +: 8]); fe = int'(m_regs[i]); end
            bad++;
         end
      check({tag, " register bank"}, fa, fe);
      check({tag, " mismatching registers"}, bad, 0);
   endtask

   task automatic wr_txn(input string tag, input int p, input int n, input int gm);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte({ADDR, 1'b0}, 0, ack); check({tag, " R4 address ACK"}, ack, 1);
      b = 8'($urandom) & 8'hF0 | 8'(p % NREG);
      send_byte(b, gm, ack); check({tag, " R5 pointer ACK"}, ack, 1);
      m_ptr = p % NREG;
      for (int i = 0; i < n; i++) begin
         b = 8'($urandom);
         send_byte(b, gm, ack); check({tag, " R5 data ACK"}, ack, 1);
         m_regs[m_ptr] = b;
         m_ptr = (m_ptr + 1) % NREG;
      end
      bus_stop();
      wq(20);
      check_regs(tag);
   endtask

   task automatic rd_txn(input string tag, input int n, input bit set_ptr, input int p);
      logic ack, s;
      logic [7:0] b;
      bus_start();
      if (set_ptr) begin
         send_byte({ADDR, 1'b0}, 0, ack); check({tag, " R4 address ACK"}, ack, 1);
         send_byte(8'(p), 0, ack); check({tag, " R9 pointer ACK"}, ack, 1);
         m_ptr = p % NREG;
         bus_rstart();
      end
      send_byte({ADDR, 1'b1}, 0, ack); check({tag, " R4 read address ACK"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n - 1, b);
         check({tag, " R7 R9 read data"}, int'(b), int'(m_regs[m_ptr]));
         if (i != n - 1) m_ptr = (m_ptr + 1) % NREG;
      end
      oe_seen = 1'b0;
      for (int i = 0; i < 3; i++) bit_io(1'b1, 0, s);
      check({tag, " R8 released after NACK"}, int'(oe_seen), 0);
      bus_stop();
   endtask

   task automatic bad_txn(input string tag, input logic [6:0] a);
      logic ack;
      bus_start();
      oe_seen = 1'b0;
      send_byte({a, 1'b0}, 0, ack);
      send_byte(8'h03, 0, ack);
      send_byte(8'hA5, 0, ack);
      check({tag, " R3 no drive on foreign address"}, int'(oe_seen), 0);
      bus_stop();
      wq(20);
      check_regs({tag, " R3"});
   endtask

   initial begin
      repeat (198000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic ack;
      void'($urandom(32'd4242));
      for (int i = 0; i < NREG; i++) m_regs[i] = 8'h00;
      wq(10); rst_n = 1'b1; wq(30);
      // R1 reset state
      check("R1 sda_oe after reset", int'(sda_oe), 0);
      check_regs("R1 reset");

      // R3 foreign addresses, one differing only in the MSB
      bad_txn("addr 0x58", 7'h58);
      bad_txn("addr 0x19", 7'h19);

      // R6 write wraps across the top register; R12 fast rate
      wr_txn("R6 R12 fast wrap write", 14, 4, 0);
      // R6 R9 read wrapping, pointer set then repeated START
      rd_txn("R6 wrap read", 3, 1'b1, 15);
      // R7 read continues from the held pointer
      rd_txn("R7 continue read", 2, 1'b0, 0);

      // R2 glitches on SDA in the high phase and on SCL in the low phase
      wr_txn("R2 SDA glitch", 5, 2, 1);
      wr_txn("R2 SCL glitch", 9, 2, 2);

      // R10 STOP inside a data byte
      bus_start();
      send_byte({ADDR, 1'b0}, 0, ack); check("R10 address ACK", ack, 1);
      send_byte(8'h02, 0, ack);
      begin
         logic s;
         for (int i = 0; i < 4; i++) bit_io(1'b0, 0, s);
      end
      bus_stop(); wq(20);
      check_regs("R10 partial byte dropped");
      m_ptr = 2;
      wr_txn("R10 after stop", 2, 1, 0);

      // constrained random mix
      for (int t = 0; t < 7; t++) begin
         int k;
         k = int'($urandom % 3);
         if (k == 0) wr_txn("R5 random write", int'($urandom % NREG), 1 + int'($urandom % 3), 0);
         else if (k == 1) rd_txn("R7 random read", 1 + int'($urandom % 3), 1'($urandom), int'($urandom % NREG));
         else begin
            logic [6:0] a;
            a = 7'($urandom);
            if (a == ADDR) a = a ^ 7'h01;
            bad_txn("R3 random address", a);
         end
      end

      // R12 standard rate, 100 kHz bit time
      q = 500;
      wr_txn("R12 slow write", 6, 1, 0);
      q = 50;

      check("R11 sda_oe moves while SCL high", oe_moves, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule